// File: doc/BRIEF.md
# Descriptor Ring with Wrap-Count Stamping

This block is a small on-chip ring of fixed-size descriptors shared by one producer and one consumer. Each descriptor is eight 32-bit words. When the producer accepts a descriptor, it replaces the top word with block-owned content before storing it. That word gets a 4-bit lap stamp in bits [31:28], the configured 8-bit ring identifier in bits [27:20], and zeros in bits [19:0]. The producer counts its wraps around the ring. Entries written on the first pass carry stamp 1, the second pass stamp 2, and so on. The stamp wraps from 15 back to 0.

The consumer never looks at the producer's write index. It keeps an expected phase that starts at 1 and flips whenever its own read index wraps. The slot under the read index holds a fresh descriptor exactly when that slot's stamp LSB equals the expected phase. All slots are cleared at reset, so no slot is taken as fresh before it is written. The producer stalls when the ring is full: the write index equals the read index and the two sides' wrap parities differ. Both sides use a valid/ready handshake.

Top module: `desc_ring`

## Requirements
- R1: After reset, `push_ready_o`=1, `full_o`=0, `pop_valid_o`=0 and `empty_o`=1.
- R2: Descriptors leave in the order they were accepted, and words 0 to 6 (bits [223:0]) are delivered unchanged.
- R3: Word 7 of a delivered descriptor carries the `ring_id_i` value present when it was accepted in bits [251:244]. Bits [243:224] are zero whatever the producer supplied.
- R4: Bits [255:252] of a delivered descriptor equal (number of completed producer wraps before its acceptance + 1) mod 16. The first pass therefore stamps 1, and the sixteenth pass stamps 0.
- R5: Once DEPTH descriptors are held unconsumed, `push_ready_o` is 0 and `full_o` is 1. A push offered while full is not accepted and overwrites no stored descriptor.
- R6: `pop_valid_o` is 1 exactly when at least one accepted descriptor has not been popped. It rises the cycle after the first acceptance into an empty ring, and `empty_o` is its inverse.
- R7: A descriptor moves only in a cycle where its valid and ready are both 1. While `pop_valid_o` is 1 and `pop_ready_i` is 0, `pop_data_o` holds its value.
- R8: `push_ready_o` depends only on registered state. A pop in the same cycle as a full ring does not let a push in during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_id_i | input | 8 | Ring identifier stamped into word 7 |
| push_valid_i | input | 1 | Producer offers a descriptor |
| push_ready_o | output | 1 | Ring can accept a descriptor |
| push_data_i | input | 256 | Descriptor, word k in bits [32k+31:32k] |
| pop_valid_o | output | 1 | Slot at read index holds a fresh descriptor |
| pop_ready_i | input | 1 | Consumer takes the descriptor |
| pop_data_o | output | 256 | Descriptor at read index |
| full_o | output | 1 | Ring full |
| empty_o | output | 1 | No fresh descriptor at read index |

## Verification
The checker keeps its own occupancy count and pop-side lap count. On every cycle it compares them against the ring's behaviour:
- ready tracks occupancy below DEPTH;
- valid tracks non-zero occupancy;
- the lap stamp on each offered descriptor is correct;
- the reserved bits are zero;
- a stalled output holds steady.

Only the bench scenarios show the rest:
- ordering and unchanged payload across more than sixteen producer passes;
- the ring identifier taken at acceptance;
- a blocked push leaving stored descriptors intact;
- the registered-only ready when a pop meets a full ring.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 8;
  localparam int ENTRY_W  = WORD_W * N_WORDS;
  localparam int LAP_W    = 4;
  localparam int RID_W    = 8;
  localparam int RSV_W    = WORD_W - LAP_W - RID_W;
  localparam int TOP_LSB  = (N_WORDS - 1) * WORD_W;
  localparam int LAP_LSB  = TOP_LSB + RSV_W + RID_W;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [LAP_W-1:0]   lap_t;
  typedef logic [RID_W-1:0]   rid_t;

  function automatic entry_t stamp_entry(entry_t e, lap_t lap, rid_t rid);
    entry_t r;
    r = e;
    r[ENTRY_W-1:TOP_LSB] = {lap, rid, {RSV_W{1'b0}}};
    return r;
  endfunction
endpackage

// File: rtl/desc_ring_prod.sv
module desc_ring_prod
  import desc_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  entry_t           push_data_i,
  input  rid_t             ring_id_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             rd_wrap_par_i,
  output logic             push_ready_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output entry_t           wr_data_o
);
  logic [IDX_W-1:0] wr_idx_q;
  lap_t             wraps_q;  // completed passes
  logic             full;
  logic             last;

  assign full         = (wr_idx_q == rd_idx_i) && (wraps_q[0] != rd_wrap_par_i);
  assign push_ready_o = !full;
  assign wr_en_o      = push_valid_i && !full;
  assign wr_idx_o     = wr_idx_q;
  assign last         = (wr_idx_q == IDX_W'(DEPTH - 1));
  // pass n (from 1) stamps n mod 16
  assign wr_data_o    = stamp_entry(push_data_i, wraps_q + lap_t'(1), ring_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      wraps_q  <= '0;
    end else if (wr_en_o) begin
      wr_idx_q <= last ? '0 : wr_idx_q + IDX_W'(1);
      if (last) wraps_q <= wraps_q + lap_t'(1);
    end
  end
endmodule

// File: rtl/desc_ring_store.sv
module desc_ring_store
  import desc_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  entry_t           wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output entry_t           rd_data_o
);
  entry_t mem_q [DEPTH];

  // cleared slots hold lap LSB 0, never matching the initial phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) mem_q[s] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/desc_ring_cons.sv
module desc_ring_cons #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_lap_lsb_i,
  input  logic             pop_ready_i,
  output logic             pop_valid_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             rd_wrap_par_o
);
  logic [IDX_W-1:0] rd_idx_q;
  logic             wrap_par_q;
  logic             phase;
  logic             last;

  assign phase         = !wrap_par_q;  // expected stamp LSB, 1 after reset
  assign pop_valid_o   = (slot_lap_lsb_i == phase);
  assign rd_idx_o      = rd_idx_q;
  assign rd_wrap_par_o = wrap_par_q;
  assign last          = (rd_idx_q == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q   <= '0;
      wrap_par_q <= 1'b0;
    end else if (pop_valid_o && pop_ready_i) begin
      rd_idx_q <= last ? '0 : rd_idx_q + IDX_W'(1);
      if (last) wrap_par_q <= !wrap_par_q;
    end
  end
endmodule

// File: rtl/desc_ring.sv
module desc_ring
  import desc_ring_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   ring_id_i,
  input  logic         push_valid_i,
  output logic         push_ready_o,
  input  logic [255:0] push_data_i,
  output logic         pop_valid_o,
  input  logic         pop_ready_i,
  output logic [255:0] pop_data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  entry_t           wr_data;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_wrap_par;
  entry_t           rd_data;

  desc_ring_prod #(.DEPTH(DEPTH)) u_prod (
    .clk_i, .rst_ni,
    .push_valid_i, .push_data_i, .ring_id_i,
    .rd_idx_i(rd_idx), .rd_wrap_par_i(rd_wrap_par),
    .push_ready_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  desc_ring_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  desc_ring_cons #(.DEPTH(DEPTH)) u_cons (
    .clk_i, .rst_ni,
    .slot_lap_lsb_i(rd_data[LAP_LSB]),
    .pop_ready_i,
    .pop_valid_o,
    .rd_idx_o(rd_idx), .rd_wrap_par_o(rd_wrap_par)
  );

  assign pop_data_o = rd_data;
  assign full_o     = !push_ready_o;
  assign empty_o    = !pop_valid_o;
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int DEPTH = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         push_valid_i,
  input logic         push_ready_o,
  input logic         pop_valid_o,
  input logic         pop_ready_i,
  input logic [255:0] pop_data_o
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic [CNT_W-1:0] occ_q;
  logic [IDX_W-1:0] pops_q;
  logic [3:0]       pop_laps_q;
  logic             push_fire, pop_fire;

  assign push_fire = push_valid_i && push_ready_o;
  assign pop_fire  = pop_valid_o && pop_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q      <= '0;
      pops_q     <= '0;
      pop_laps_q <= '0;
    end else begin
      occ_q <= occ_q + CNT_W'(push_fire) - CNT_W'(pop_fire);
      if (pop_fire) begin
        pops_q <= (pops_q == IDX_W'(DEPTH - 1)) ? '0 : pops_q + IDX_W'(1);
        if (pops_q == IDX_W'(DEPTH - 1)) pop_laps_q <= pop_laps_q + 4'd1;
      end
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q <= CNT_W'(DEPTH)) && (push_ready_o == (occ_q != CNT_W'(DEPTH))));

  assert_valid_occ_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o == (occ_q != '0));

  assert_hold_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_valid_o && !pop_ready_i) |=> (pop_valid_o && $stable(pop_data_o)));

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> (pop_data_o[243:224] == 20'h0));

  assert_lap_stamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> (pop_data_o[255:252] == pop_laps_q + 4'd1));
endmodule

bind desc_ring desc_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .push_valid_i(push_valid_i), .push_ready_o(push_ready_o),
  .pop_valid_o(pop_valid_o), .pop_ready_i(pop_ready_i),
  .pop_data_o(pop_data_o)
);

// File: tb/desc_ring_tb.sv
`timescale 1ns/1ps
module desc_ring_tb;
  localparam int DEPTH = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   ring_id_i = 8'h00;
  logic         push_valid_i = 1'b0;
  logic         push_ready_o;
  logic [255:0] push_data_i = '0;
  logic         pop_valid_o;
  logic         pop_ready_i = 1'b0;
  logic [255:0] pop_data_o;
  logic         full_o, empty_o;

  int n_chk = 0, n_fail = 0, n_acc = 0;
  bit done = 0;
  logic [255:0] sb_q [$];

  always #2.5 clk_i = !clk_i;

  desc_ring #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input int n);
    logic [255:0] d;
    for (int k = 0; k < 7; k++) d[32*k +: 32] = {n[15:0], 8'(k), 8'h5A} ^ 32'(n * 97);
    d[255:224] = 32'hFFFF_FFFF ^ 32'(n);
    return d;
  endfunction

  task automatic push_entry(input logic [255:0] d);
    logic [255:0] e;
    @(negedge clk_i);
    push_valid_i = 1'b1;
    push_data_i  = d;
    #1;
    while (!push_ready_o) begin @(negedge clk_i); #1; end
    e = d;
    e[255:224] = {4'((n_acc / DEPTH) + 1), ring_id_i, 20'h0};
    sb_q.push_back(e);
    n_acc++;
    @(posedge clk_i);
    #0.5 push_valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && pop_valid_o && pop_ready_i) begin
      if (sb_q.size() == 0) chk(0, "R6 pop with nothing pushed", 256'(pop_valid_o), 256'h0);
      else begin
        logic [255:0] e;
        e = sb_q.pop_front();
        chk(pop_data_o[223:0] == e[223:0], "R2 payload/order", pop_data_o, e);
        chk(pop_data_o[251:244] == e[251:244], "R3 ring id", 256'(pop_data_o[251:244]), 256'(e[251:244]));
        chk(pop_data_o[243:224] == 20'h0, "R3 reserved zero", 256'(pop_data_o[243:224]), 256'h0);
        chk(pop_data_o[255:252] == e[255:252], "R4 lap stamp", 256'(pop_data_o[255:252]), 256'(e[255:252]));
      end
    end
  end

  task automatic drain();
    @(negedge clk_i);
    pop_ready_i = 1'b1;
    while (sb_q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    #1;
    chk(pop_valid_o == 1'b0, "R6 valid low after drain", 256'(pop_valid_o), 256'h0);
    chk(empty_o == 1'b1, "R6 empty after drain", 256'(empty_o), 256'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(push_ready_o == 1'b1 && full_o == 1'b0, "R1 reset ready", {push_ready_o, full_o}, 256'h2);
    chk(pop_valid_o == 1'b0 && empty_o == 1'b1, "R1 reset empty", {pop_valid_o, empty_o}, 256'h1);
    rst_ni = 1'b1;

    // R6: valid rises the cycle after first acceptance
    ring_id_i = 8'h3C;
    @(negedge clk_i);
    push_valid_i = 1'b1;
    push_data_i  = mk(0);
    #1;
    chk(pop_valid_o == 1'b0, "R6 not valid before write", 256'(pop_valid_o), 256'h0);
    sb_q.push_back({4'h1, 8'h3C, 20'h0, push_data_i[223:0]});
    n_acc++;
    @(posedge clk_i);
    #0.5 push_valid_i = 1'b0;
    #1;
    chk(pop_valid_o == 1'b1, "R6 valid after one write", 256'(pop_valid_o), 256'h1);

    // R5: fill to full with consumer stalled
    for (int i = 1; i < DEPTH; i++) begin
      ring_id_i = 8'(8'h40 + i);
      push_entry(mk(i));
    end
    @(negedge clk_i);
    #1;
    chk(push_ready_o == 1'b0 && full_o == 1'b1, "R5 full", {push_ready_o, full_o}, 256'h1);
    // offered push while full must not land
    push_valid_i = 1'b1;
    push_data_i  = mk(999);
    repeat (3) @(negedge clk_i);
    #1;
    chk(full_o == 1'b1, "R5 still full under push", 256'(full_o), 256'h1);
    chk(pop_data_o[223:0] == sb_q[0][223:0], "R5 head not overwritten", pop_data_o, sb_q[0]);
    push_valid_i = 1'b0;
    // R8: pop against full ring does not open ready that cycle
    @(negedge clk_i);
    pop_ready_i = 1'b1;
    #1;
    chk(push_ready_o == 1'b0, "R8 ready registered-only", 256'(push_ready_o), 256'h0);
    @(negedge clk_i);
    pop_ready_i = 1'b0;
    #1;
    chk(push_ready_o == 1'b1, "R5 ready after one pop", 256'(push_ready_o), 256'h1);
    drain();

    // R4/R2: stream across more than sixteen producer passes
    pop_ready_i = 1'b0;
    fork
      begin
        for (int i = 0; i < 150; i++) begin
          ring_id_i = 8'(i * 7);
          push_entry(mk(1000 + i));
        end
      end
      begin
        for (int c = 0; c < 900; c++) begin
          @(negedge clk_i);
          pop_ready_i = (c % 3) != 0;
        end
      end
    join
    drain();
    chk(n_acc == 158, "R2 accepted count", 256'(n_acc), 256'd158);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule